// File: doc/BRIEF.md
# Shared Timebase with Per-Core Compare Timers

This block holds one free-running counter shared by all cores and a 64-bit compare register for each core. When the counter reaches a core's compare value, that core's timer interrupt line goes high and stays high until the core writes its compare register again. Cores access the block over a simple word-addressed register port. Each request carries the number of the core that issued it, so the same address can reach a different compare register depending on who is asking.

A core programs its own compare register through the local window. It can program any other core's compare register through the remote window, which targets the core named in the requester's own target-select register. The counter is `CNT_W` bits wide, where `CNT_W` is a multiple of 4 from 32 to 64. It is read as two 32-bit halves. Software reads high, low, then high again, and retries if the two high values differ. A stop bit in the configuration register freezes the counter.

Register map (word addresses): 0 configuration, 1 count low, 2 count high, 4 target select, 5 local compare low, 6 local compare high, 9 remote compare low, 10 remote compare high.

Top module: `shared_timebase`

## Requirements
- R1: After reset the counter holds `CNT_START`. While the stop bit is 0 it increases by one on every clock edge and wraps modulo 2^`CNT_W`.
- R2: Writing 1 to bit 0 of address 0 freezes the counter from the edge after the write. Writing 0 resumes counting from the edge after that write. At the edge where the write lands, the counter follows the old value of the stop bit.
- R3: Address 1 returns count bits 31:0 and address 2 returns bits 63:32. Bits at or above `CNT_W` read as zero, and a carry out of bit 31 shows up in the high half on the same edge.
- R4: Address 0 reads the stop bit in bit 0, (`CNT_W`-32)/4 in bits 11:8, `CORES`-1 in bits 19:16, and zero in all other bits.
- R5: Writes to address 5 (bits 31:0) and address 6 (bits 63:32) update only the requesting core's compare register. Reads of the same addresses return the requesting core's compare value.
- R6: Writes to address 9 (low) and address 10 (high) update the compare register of the core named in the requester's target-select register at address 4. That register is readable, and is one per core. Reads of addresses 9 and 10 return that core's compare value. No other core's compare register changes.
- R7: A core's interrupt goes high on the edge after a cycle in which the zero-extended counter equals its compare value, whether or not the counter is stopped. It then stays high.
- R8: Any write to either half of a core's compare register clears that core's interrupt on the edge of the write. If the counter still matches, the interrupt goes high again on the next edge.
- R9: Reset clears the interrupts, the stop bit and the target-select registers, sets every compare register to all ones, and clears the read data.
- R10: Read data appears on the edge after the read request and is zero after any cycle with no read. Writes to addresses 1 and 2 change nothing, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Register request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_core | input | CORE_W | Number of the requesting core |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| timer_irq | output | CORES | Per-core timer interrupt |

## Verification
The bench starts the counter just below a 32-bit boundary. The carry into the high half is therefore visible within a few cycles. A design that kept the halves in separate registers, or ignored bits beyond 32, would return a wrong high word. A second, 32-bit-wide instance shows wrap-around and a zero high half.

Interrupt timing is checked at exact cycles after the stop bit is cleared. An off-by-one in the stop handling or a combinational interrupt moves the rising edge. The remote window is checked against the requester's own compare value to catch a decoder that writes the wrong core. Writing a compare register that still matches a stopped counter exposes a design that fails to clear on write or fails to set again.

// File: rtl/stb_pkg.sv
package stb_pkg;

   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;
   localparam int WIDE_W = 64;

   typedef enum logic [ADDR_W-1:0] {
      RA_CONFIG   = 4'd0,
      RA_COUNT_LO = 4'd1,
      RA_COUNT_HI = 4'd2,
      RA_TARGET   = 4'd4,
      RA_LOCAL_LO = 4'd5,
      RA_LOCAL_HI = 4'd6,
      RA_REMOTE_LO = 4'd9,
      RA_REMOTE_HI = 4'd10
   } reg_addr_e;

   function automatic logic [3:0] width_code(input int w);
      return 4'((w - 32) / 4);
   endfunction

endpackage

// File: rtl/stb_counter.sv
module stb_counter #(
   parameter int          CNT_W     = 48,
   parameter logic [63:0] CNT_START = '0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic        cfg_stop,
   output logic        stop,
   output logic [63:0] cnt_wide
);

   logic [CNT_W-1:0] cnt_q;
   logic             stop_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= CNT_START[CNT_W-1:0];
         stop_q <= 1'b0;
      end else begin
         if (cfg_we)
            stop_q <= cfg_stop;
         if (!stop_q)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   generate
      if (CNT_W == 64) begin : g_full
         assign cnt_wide = cnt_q;
      end else begin : g_padded
         assign cnt_wide = {{(64-CNT_W){1'b0}}, cnt_q};
      end
   endgenerate

   assign stop = stop_q;

   // R1
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(stop_q)) |-> (cnt_q - $past(cnt_q) == CNT_W'(1)));

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(stop_q)) |-> $stable(cnt_q));

endmodule

// File: rtl/stb_cmp_slot.sv
module stb_cmp_slot (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wdata,
   input  logic [63:0] cnt_wide,
   output logic [63:0] cmp,
   output logic        irq
);

   logic [63:0] cmp_q;
   logic        irq_q;
   logic        match;

   assign match = (cnt_wide == cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '1;
         irq_q <= 1'b0;
      end else begin
         if (wr_hi)
            cmp_q[63:32] <= wdata;
         if (wr_lo)
            cmp_q[31:0] <= wdata;
         if (wr_lo || wr_hi)
            irq_q <= 1'b0;
         else if (match)
            irq_q <= 1'b1;
      end
   end

   assign cmp = cmp_q;
   assign irq = irq_q;

   // R7
   match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(match) && !$past(wr_lo || wr_hi)) |-> irq_q);

   // R7
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_q) && !$past(wr_lo || wr_hi)) |-> irq_q);

   // R8
   write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_lo || wr_hi) |-> !irq_q);

   // R7
   rise_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(match));

endmodule

// File: rtl/shared_timebase.sv
module shared_timebase
   import stb_pkg::*;
#(
   parameter int          CORES     = 2,
   parameter int          CNT_W     = 48,
   parameter logic [63:0] CNT_START = '0,
   localparam int         CORE_W    = (CORES > 1) ? $clog2(CORES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [CORE_W-1:0] bus_core,
   input  logic [3:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [CORES-1:0]  timer_irq
);

   generate
      if (CNT_W < 32 || CNT_W > 64 || (CNT_W % 4) != 0) begin : g_bad_width
         $error("CNT_W must be a multiple of 4 between 32 and 64");
      end
      if (CORES < 1 || CORES > 16) begin : g_bad_cores
         $error("CORES must be between 1 and 16");
      end
   endgenerate

   localparam logic [3:0] WCODE = width_code(CNT_W);
   localparam logic [3:0] NCODE = 4'(CORES - 1);

   reg_addr_e         addr_e;
   logic              wr_en;
   logic              req_ok;
   logic [CORE_W-1:0] tgt;
   logic              tgt_ok;
   logic              stop;
   logic [63:0]       cnt_wide;
   logic [63:0]       cmp_w [CORES];
   logic [CORE_W-1:0] sel_q [CORES];
   logic [CORES-1:0]  wr_lo;
   logic [CORES-1:0]  wr_hi;
   logic [31:0]       rd_mux;
   logic [31:0]       rdata_q;

   assign addr_e = reg_addr_e'(bus_addr);
   assign wr_en  = bus_valid && bus_write;

   always_comb begin
      req_ok = (32'(bus_core) < CORES);
      tgt    = req_ok ? sel_q[bus_core] : '0;
      tgt_ok = req_ok && (32'(tgt) < CORES);
   end

   stb_counter #(
      .CNT_W     (CNT_W),
      .CNT_START (CNT_START)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (wr_en && addr_e == RA_CONFIG),
      .cfg_stop (bus_wdata[0]),
      .stop     (stop),
      .cnt_wide (cnt_wide)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < CORES; i++)
            sel_q[i] <= '0;
      end else if (wr_en && addr_e == RA_TARGET && req_ok) begin
         sel_q[bus_core] <= bus_wdata[CORE_W-1:0];
      end
   end

   generate
      for (genvar c = 0; c < CORES; c++) begin : g_core
         logic own_req;
         logic remote_req;

         assign own_req    = req_ok && bus_core == CORE_W'(c);
         assign remote_req = tgt_ok && tgt == CORE_W'(c);

         assign wr_lo[c] = wr_en &&
            ((addr_e == RA_LOCAL_LO  && own_req) ||
             (addr_e == RA_REMOTE_LO && remote_req));
         assign wr_hi[c] = wr_en &&
            ((addr_e == RA_LOCAL_HI  && own_req) ||
             (addr_e == RA_REMOTE_HI && remote_req));

         stb_cmp_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo[c]),
            .wr_hi    (wr_hi[c]),
            .wdata    (bus_wdata),
            .cnt_wide (cnt_wide),
            .cmp      (cmp_w[c]),
            .irq      (timer_irq[c])
         );
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      case (addr_e)
         RA_CONFIG:    rd_mux = {12'b0, NCODE, 4'b0, WCODE, 7'b0, stop};
         RA_COUNT_LO:  rd_mux = cnt_wide[31:0];
         RA_COUNT_HI:  rd_mux = cnt_wide[63:32];
         RA_TARGET:    if (req_ok) rd_mux = 32'(sel_q[bus_core]);
         RA_LOCAL_LO:  if (req_ok) rd_mux = cmp_w[bus_core][31:0];
         RA_LOCAL_HI:  if (req_ok) rd_mux = cmp_w[bus_core][63:32];
         RA_REMOTE_LO: if (tgt_ok) rd_mux = cmp_w[tgt][31:0];
         RA_REMOTE_HI: if (tgt_ok) rd_mux = cmp_w[tgt][63:32];
         default:      rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else
         rdata_q <= (bus_valid && !bus_write) ? rd_mux : '0;
   end

   assign bus_rdata = rdata_q;

   // R10
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_valid && !bus_write) |-> (bus_rdata == '0));

   // R6
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_lo, wr_hi}));

   // R9
   reset_irq_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (timer_irq == '0));

endmodule

// File: tb/shared_timebase_test.sv
module shared_timebase_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [0:0]  bus_core = '0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata_w, rdata_n;
   logic [1:0]  irq_w, irq_n;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   shared_timebase #(.CORES(2), .CNT_W(48), .CNT_START(64'h0000_0000_FFFF_FFFF)) uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rdata_w), .timer_irq(irq_w));

   shared_timebase #(.CORES(2), .CNT_W(32), .CNT_START(64'h0000_0000_FFFF_FFFE)) uut_narrow (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rdata_n), .timer_irq(irq_n));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [0:0] core, input logic [3:0] addr, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_core = core; bus_addr = addr; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [0:0] core, input logic [3:0] addr,
                     output logic [31:0] w, output logic [31:0] n);
      bus_valid = 1'b1; bus_write = 1'b0; bus_core = core; bus_addr = addr;
      @(negedge clk);
      bus_valid = 1'b0;
      w = rdata_w; n = rdata_n;
   endtask

   // stop the counter is cleared at edge k; target = frozen + d; irq expected at k+d+1
   task automatic irq_timing(input int core, input int d, input string req);
      wr(0, 4'd0, 32'd0);
      for (int i = 1; i <= d; i++) begin
         chk(req, irq_w[core], 1'b0);
         @(negedge clk);
      end
      chk(req, irq_w[core], 1'b0);
      @(negedge clk);
      chk(req, irq_w[core], 1'b1);
   endtask

   initial begin
      logic [31:0] a, b, vhi, vlo;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 irq", {irq_n, irq_w}, 4'b0000);
      chk("R9 rdata", {rdata_n, rdata_w}, 64'd0);

      rst_n = 1'b1;
      rd(0, 4'd1, a, b);
      chk("R1 start wide", a, 32'hFFFF_FFFF);
      chk("R1 start narrow", b, 32'hFFFF_FFFE);
      rd(0, 4'd1, a, b);
      chk("R1 step wide", a, 32'h0000_0000);
      chk("R1 step narrow wrap", b, 32'hFFFF_FFFF);
      wr(0, 4'd0, 32'd1);
      rd(0, 4'd2, a, b);
      chk("R3 carry high half", a, 32'd1);
      chk("R3 narrow high zero", b, 32'd0);
      rd(0, 4'd1, a, b);
      chk("R2 frozen wide", a, 32'd2);
      chk("R2 frozen narrow", b, 32'd1);
      repeat (5) @(negedge clk);
      rd(0, 4'd1, a, b);
      chk("R2 still frozen", {b, a}, {32'd1, 32'd2});
      rd(1, 4'd0, a, b);
      chk("R4 config wide", a, 32'h0001_0401);
      chk("R4 config narrow", b, 32'h0001_0001);

      wr(0, 4'd1, 32'h1234);
      wr(1, 4'd2, 32'h55);
      rd(0, 4'd1, a, b);
      chk("R10 count write ignored lo", a, 32'd2);
      rd(0, 4'd2, a, b);
      chk("R10 count write ignored hi", a, 32'd1);
      rd(0, 4'd3, a, b);
      chk("R10 unmapped", a, 32'd0);
      @(negedge clk);
      chk("R10 idle rdata", rdata_w, 32'd0);

      rd(0, 4'd5, a, b);
      chk("R9 compare reset lo", a, 32'hFFFF_FFFF);
      rd(1, 4'd6, a, b);
      chk("R9 compare reset hi", a, 32'hFFFF_FFFF);
      rd(1, 4'd4, a, b);
      chk("R9 select reset", a, 32'd0);

      // R5 local window, counter frozen at 0x1_0000_0002
      wr(0, 4'd6, 32'd1);
      wr(0, 4'd5, 32'd5);
      chk("R5 no early irq", irq_w, 2'b00);
      rd(0, 4'd5, a, b);
      chk("R5 readback lo", a, 32'd5);
      rd(0, 4'd6, a, b);
      chk("R5 readback hi", a, 32'd1);
      rd(1, 4'd5, a, b);
      chk("R5 other core untouched", a, 32'hFFFF_FFFF);

      irq_timing(0, 3, "R7 irq0 timing");
      chk("R7 irq1 quiet", irq_w[1], 1'b0);
      repeat (4) @(negedge clk);
      chk("R7 sticky", irq_w[0], 1'b1);
      wr(0, 4'd5, 32'd5);
      chk("R8 clear on write", irq_w[0], 1'b0);
      repeat (2) @(negedge clk);
      chk("R8 stays clear", irq_w[0], 1'b0);

      // R6 remote window
      wr(0, 4'd0, 32'd1);
      rd(0, 4'd2, vhi, b);
      rd(0, 4'd1, vlo, b);
      wr(0, 4'd4, 32'd1);
      rd(0, 4'd4, a, b);
      chk("R6 select readback", a, 32'd1);
      wr(0, 4'd10, vhi);
      wr(0, 4'd9, vlo + 32'd4);
      rd(1, 4'd5, a, b);
      chk("R6 remote lo landed", a, vlo + 32'd4);
      rd(1, 4'd6, a, b);
      chk("R6 remote hi landed", a, vhi);
      rd(0, 4'd9, a, b);
      chk("R6 remote read", a, vlo + 32'd4);
      rd(0, 4'd5, a, b);
      chk("R6 requester untouched", a, 32'd5);
      irq_timing(1, 4, "R6 R7 irq1 timing");
      chk("R7 irq0 quiet", irq_w[0], 1'b0);

      // R7 match while stopped, R8 re-set
      wr(0, 4'd0, 32'd1);
      rd(1, 4'd2, vhi, b);
      rd(1, 4'd1, vlo, b);
      wr(1, 4'd6, vhi);
      chk("R8 hi write clears", irq_w[1], 1'b0);
      wr(1, 4'd5, vlo);
      chk("R8 lo write clears", irq_w[1], 1'b0);
      @(negedge clk);
      chk("R7 match while stopped", irq_w[1], 1'b1);
      wr(1, 4'd5, vlo);
      chk("R8 clear despite match", irq_w[1], 1'b0);
      @(negedge clk);
      chk("R8 re-set next edge", irq_w[1], 1'b1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule